// File: doc/BRIEF.md
# Dual Wiper Code Controller with Two-Wire Serial Slave

This block is a two-wire serial (I2C) slave that owns the digital state of a two-channel digital potentiometer: one wiper code per channel and one shutdown flag per channel. It runs on a fast internal system clock. It oversamples the SCL and SDA pins through a short synchronizer and finds bus edges, START and STOP on that clock. It answers the bus only by pulling SDA low through an open-drain output enable. The analog ladder outside the block uses the two codes and the two shutdown flags.

A write transfer has three bytes: the device address with the write bit, an instruction byte and a data byte. The instruction byte picks the channel and sets that channel's shutdown flag. The data byte loads the code of the picked channel. A read transfer has no channel field. It sends back the code of the channel picked by the most recent instruction byte, and it repeats that byte for as long as the master acknowledges. An instruction byte alone, with no data byte, is enough to move the read selection. Reset loads both codes with midscale.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Until a START has been seen, the block ignores all clocked bits and never drives SDA.
- R2: The first byte after a START is the 7-bit device address 0101111, sent MSB first, followed by a direction bit (1 = read, 0 = write). On a match the block pulls SDA low for the whole ninth clock.
- R3: On an address mismatch the block does not acknowledge, ignores later bytes and waits for the next START.
- R4: A write is address, instruction and data. The block acknowledges each of the three bytes, and the data byte becomes the code of the selected channel.
- R5: In the instruction byte, bit 7 selects the channel (0 = channel A, 1 = channel B) and bit 6 is that channel's shutdown value. Bits 5 to 0 have no effect.
- R6: A shutdown bit of 1 raises the selected channel's shutdown output and leaves its stored code unchanged. A shutdown bit of 0 lowers that output while the code stays as stored.
- R7: A data byte written to a channel that is in shutdown still updates that channel's code.
- R8: A read sends the code of the most recently selected channel, MSB first, starting right after the address acknowledge. A write that ends after the instruction byte still changes the selection.
- R9: During a read, a master acknowledge (SDA low on the ninth clock) makes the block send the same code again. A master not-acknowledge makes it release SDA until a STOP.
- R10: After reset both codes are 0x80, both shutdown outputs are 0, and SDA is released.
- R11: A STOP before the data byte is complete commits no code. A repeated START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock pin level |
| sda_in | input | 1 | Serial data pin level (wired-AND bus) |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| wiper_a_code | output | 8 | Stored code of channel A |
| wiper_b_code | output | 8 | Stored code of channel B |
| wiper_a_off | output | 1 | Shutdown flag of channel A |
| wiper_b_off | output | 1 | Shutdown flag of channel B |

## Verification
Full writes are driven from a table of instruction and data pairs. The pairs alternate channels, so a wrong channel decode moves the wrong code. Some pairs set junk low bits to show that only bits 7 and 6 count, and some write data under shutdown to show the code is stored anyway. Each write is followed by a read whose expected value depends only on the selected channel, which separates the read selection from the last channel written. Directed transfers then cover clocking with no START, a wrong address, instruction-only writes that toggle shutdown, ack versus not-ack during a read, a STOP in the middle of the data byte, and a repeated START after the instruction byte. Each of these has a distinct expected result at the code outputs, the shutdown outputs or the SDA line.

// File: rtl/wpot_pkg.sv
`timescale 1ns/1ps
package wpot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_INSTR,
    ST_IACK,
    ST_DATA,
    ST_DACK,
    ST_RBYTE,
    ST_RACK,
    ST_WAIT
  } bus_state_t;

  // Address byte matches when its upper seven bits equal the device id.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Midscale of a code of width w: only the top bit set.
  function automatic int unsigned midscale(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

endpackage

// File: rtl/wpot_sync.sv
`timescale 1ns/1ps
module wpot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[TOP];
      sda_d <= sda_q[TOP];
    end
  end

  assign scl_lvl   = scl_q[TOP];
  assign sda_lvl   = sda_q[TOP];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/wpot_link.sv
`timescale 1ns/1ps
module wpot_link
  import wpot_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0101111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_code,
  output logic       sda_oe,
  output logic       instr_we,
  output logic       instr_ch,
  output logic       instr_sd,
  output logic       data_we,
  output logic [7:0] wdata
);
  bus_state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       rw;
  logic       mack;
  logic       byte_done;

  assign byte_done = scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      tx    <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_lvl};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit(shreg, DEV_ADDR)) begin
                rw    <= shreg[0];
                state <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_INSTR) begin
              state <= ST_IACK;
            end else begin
              state <= ST_DACK;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (rw) begin
            tx    <= rd_code;
            state <= ST_RBYTE;
          end else begin
            state <= ST_INSTR;
          end
        end
        ST_IACK: if (scl_fall) state <= ST_DATA;
        ST_DACK: if (scl_fall) state <= ST_WAIT;
        ST_RBYTE: if (scl_fall) begin
          if (cnt == 4'd7) begin
            cnt   <= '0;
            state <= ST_RACK;
          end else begin
            cnt <= cnt + 4'd1;
            tx  <= {tx[6:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_lvl;
          if (scl_fall) begin
            if (mack) begin
              tx    <= rd_code;
              state <= ST_RBYTE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Named commit strobes for the register bank and the assertions.
  assign instr_we = (state == ST_INSTR) && byte_done;
  assign data_we  = (state == ST_DATA) && byte_done;
  assign instr_ch = shreg[7];
  assign instr_sd = shreg[6];
  assign wdata    = shreg;

  assign sda_oe = (state == ST_AACK) || (state == ST_IACK) || (state == ST_DACK)
               || ((state == ST_RBYTE) && !tx[7]);

  assert_stop_goes_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (state == ST_IDLE));

  assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && cnt == 4'd0));

  assert_silent_unaddressed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ADDR || state == ST_WAIT) |-> !sda_oe);

  assert_sda_steady_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));

endmodule

// File: rtl/wpot_bank.sv
`timescale 1ns/1ps
module wpot_bank
  import wpot_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CODE_W = 8,
  localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_we,
  input  logic [IW-1:0]              instr_ch,
  input  logic                       instr_sd,
  input  logic                       data_we,
  input  logic [CODE_W-1:0]          wdata,
  output logic [NCH-1:0][CODE_W-1:0] codes,
  output logic [NCH-1:0]             sds,
  output logic [CODE_W-1:0]          rd_code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  logic [NCH-1:0][CODE_W-1:0] code_q;
  logic [NCH-1:0]             sd_q;
  logic [IW-1:0]              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      for (int i = 0; i < NCH; i++) begin
        code_q[i] <= MID;
        sd_q[i]   <= 1'b0;
      end
    end else begin
      if (instr_we) sel <= instr_ch;
      for (int i = 0; i < NCH; i++) begin
        if (instr_we && instr_ch == IW'(i)) sd_q[i] <= instr_sd;
        if (data_we && sel == IW'(i)) code_q[i] <= wdata;
      end
    end
  end

  assign codes   = code_q;
  assign sds     = sd_q;
  assign rd_code = code_q[sel];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chk
      assert_instr_keeps_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_we && !data_we) |=> $stable(codes[g]));

      assert_data_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel == IW'(g)) |=> (codes[g] == $past(wdata)));

      assert_sd_follows_instr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_we && instr_ch == IW'(g)) |=> (sds[g] == $past(instr_sd)));
    end
  endgenerate

endmodule

// File: rtl/dual_wiper_ctrl.sv
`timescale 1ns/1ps
module dual_wiper_ctrl #(
  parameter logic [6:0] DEV_ADDR    = 7'b0101111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [7:0] wiper_a_code,
  output logic [7:0] wiper_b_code,
  output logic       wiper_a_off,
  output logic       wiper_b_off
);
  localparam int NCH    = 2;
  localparam int CODE_W = 8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic instr_we, instr_ch, instr_sd, data_we;
  logic [CODE_W-1:0] wdata, rd_code;
  logic [NCH-1:0][CODE_W-1:0] codes;
  logic [NCH-1:0] sds;

  wpot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  wpot_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_code(rd_code), .sda_oe(sda_pull), .instr_we(instr_we), .instr_ch(instr_ch),
    .instr_sd(instr_sd), .data_we(data_we), .wdata(wdata)
  );

  wpot_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .instr_we(instr_we), .instr_ch(instr_ch),
    .instr_sd(instr_sd), .data_we(data_we), .wdata(wdata),
    .codes(codes), .sds(sds), .rd_code(rd_code)
  );

  assign wiper_a_code = codes[0];
  assign wiper_b_code = codes[1];
  assign wiper_a_off  = sds[0];
  assign wiper_b_off  = sds[1];

endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] wa, wb;
  logic woa, wob;
  wire  sda_bus = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_wiper_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .wiper_a_code(wa), .wiper_b_code(wb),
    .wiper_a_off(woa), .wiper_b_off(wob)
  );

  localparam logic [7:0] AW = 8'h5E;  // 0101111 + write
  localparam logic [7:0] AR = 8'h5F;  // 0101111 + read

  // {instruction, data, expected A code, expected B code, expected A off, expected B off}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {8'h00, 8'h3C, 8'h3C, 8'h80, 1'b0, 1'b0},
    {8'h80, 8'hA5, 8'h3C, 8'hA5, 1'b0, 1'b0},
    {8'h3F, 8'h01, 8'h01, 8'hA5, 1'b0, 1'b0},
    {8'hC0, 8'h77, 8'h01, 8'h77, 1'b0, 1'b1},
    {8'h80, 8'hFF, 8'h01, 8'hFF, 1'b0, 1'b0},
    {8'h40, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b0},
    {8'h00, 8'hFE, 8'hFE, 8'hFF, 1'b0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    sda_m = v;
    tick(8);
    scl_m = 1'b1;
    tick(8);
    s = sda_bus;
    tick(8);
    scl_m = 1'b0;
    tick(4);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bit_cycle(b[i], s);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~mack, s);
  endtask

  task automatic chk_outs(input string req, input logic [7:0] ea, input logic [7:0] eb,
                          input logic eoa, input logic eob);
    chk({req, " code A"}, 32'(wa), 32'(ea));
    chk({req, " code B"}, 32'(wb), 32'(eb));
    chk({req, " off A"}, 32'(woa), 32'(eoa));
    chk({req, " off B"}, 32'(wob), 32'(eob));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb, rb2;

    tick(5);
    // R10: reset state
    chk_outs("R10 reset", 8'h80, 8'h80, 1'b0, 1'b0);
    chk("R10 sda released", 32'(sda_pull), 32'd0);
    rst_n = 1'b1;
    tick(10);

    // R1: clocking a matching address and a data byte with no START gives no ack
    scl_m = 1'b0; tick(8);
    send_byte(AW, ack);
    chk("R1 no ack without start", 32'(ack), 32'd0);
    send_byte(8'h00, ack);
    send_byte(8'h11, ack);
    bus_stop(); tick(10);
    chk_outs("R1 no effect", 8'h80, 8'h80, 1'b0, 1'b0);

    // R2 R4 R5 R7 R8: table of full writes, each followed by a read
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ins, dat, ea, eb;
      logic eoa, eob;
      {ins, dat, ea, eb, eoa, eob} = VEC[v];
      bus_start();
      send_byte(AW, ack); chk("R2 address ack", 32'(ack), 32'd1);
      send_byte(ins, ack); chk("R4 instruction ack", 32'(ack), 32'd1);
      send_byte(dat, ack); chk("R4 data ack", 32'(ack), 32'd1);
      bus_stop(); tick(10);
      chk_outs("R4 R5 R7 write", ea, eb, eoa, eob);
      bus_start();
      send_byte(AR, ack); chk("R2 read address ack", 32'(ack), 32'd1);
      read_byte(1'b0, rb);
      bus_stop(); tick(10);
      chk("R8 read selected", 32'(rb), ins[7] ? 32'(eb) : 32'(ea));
    end

    // R3: wrong address, then bytes that would otherwise write
    bus_start();
    send_byte(8'h5C, ack); chk("R3 mismatch no ack", 32'(ack), 32'd0);
    send_byte(8'h80, ack); chk("R3 silent after mismatch", 32'(ack), 32'd0);
    send_byte(8'h12, ack);
    bus_stop(); tick(10);
    chk_outs("R3 no effect", 8'hFE, 8'hFF, 1'b0, 1'b0);

    // R6: instruction-only shutdown on A keeps its code, then clear
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h40, ack); chk("R6 instr ack", 32'(ack), 32'd1);
    bus_stop(); tick(10);
    chk_outs("R6 shutdown A", 8'hFE, 8'hFF, 1'b1, 1'b0);
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h00, ack);
    bus_stop(); tick(10);
    chk_outs("R6 restore A", 8'hFE, 8'hFF, 1'b0, 1'b0);

    // R8: instruction-only write moves the read selection to B
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h80, ack);
    bus_stop(); tick(10);
    bus_start();
    send_byte(AR, ack);
    read_byte(1'b0, rb);
    bus_stop(); tick(10);
    chk("R8 instr-only selects B", 32'(rb), 32'hFF);

    // R9: master ack repeats the byte; not-ack releases SDA
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h00, ack);
    bus_stop(); tick(10);
    bus_start();
    send_byte(AR, ack);
    read_byte(1'b1, rb);
    read_byte(1'b0, rb2);
    chk("R9 first byte", 32'(rb), 32'hFE);
    chk("R9 repeat after ack", 32'(rb2), 32'hFE);
    read_byte(1'b0, rb);
    chk("R9 released after nack", 32'(rb), 32'hFF);
    bus_stop(); tick(10);

    // R11: STOP inside the data byte commits nothing
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h80, ack);
    send_bits(8'h00, 4);
    bus_stop(); tick(10);
    chk_outs("R11 partial data aborted", 8'hFE, 8'hFF, 1'b0, 1'b0);

    // R11: repeated START after the instruction byte restarts addressing
    bus_start();
    send_byte(AW, ack);
    send_byte(8'h00, ack);
    bus_start();
    send_byte(AW, ack); chk("R11 repeated start ack", 32'(ack), 32'd1);
    send_byte(8'h80, ack);
    send_byte(8'h5A, ack); chk("R11 data ack", 32'(ack), 32'd1);
    bus_stop(); tick(10);
    chk_outs("R11 repeated start write", 8'hFE, 8'h5A, 1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule